// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two square unsigned matrices, C = A·B, on an N×N grid of identical multiply-accumulate cells. Each cell owns exactly one entry of C and keeps it in place. A operands move one cell to the right per clock and B operands move one cell down per clock. Every connection therefore runs only between nearest neighbours. At the array edge, the block delays row i of A by i cycles and column j of B by j cycles. As a result, a(i,k) and b(k,j) reach cell (i,j) on the same clock.

A block is streamed over N consecutive cycles. The first of these cycles is marked by `start`. On cycle k of the stream, the A bus carries column k of A and the B bus carries row k of B. After the last partial product has landed in the bottom-right cell, `done` rises and stays high. While it is high, any entry of C can be read through a combinational row/column port. The default size is an 8×8 block of 8-bit samples multiplied by an 8×8 matrix of 8-bit coefficients, with 19-bit results.

Top module: `systolic_mm_top`

## Requirements
- R1: Every result entry equals the exact unsigned sum over k of a(i,k)·b(k,j) in CW = AW+BW+log2(N) bits (19 for the defaults). With all operands at 255, each entry is 520200 and nothing wraps.
- R2: The accepted `start` cycle carries k=0, and the following N−1 cycles carry k=1..N−1. Lane i of `a_col_in` (bits [i*AW+AW-1 : i*AW]) holds a(i,k). Lane j of `b_row_in` (bits [j*BW+BW-1 : j*BW]) holds b(k,j).
- R3: After reset, and before any `start`, `done` is low and every result entry reads zero.
- R4: An accepted `start` clears all accumulators, so a new product contains no trace of the previous one.
- R5: `done` is low from the cycle after an accepted `start` until it goes high exactly 3N−2 cycles after the start cycle (cycle 22 for N=8).
- R6: Once high, `done` stays high and the result entries stay unchanged until the next accepted `start`, whatever the operand buses carry.
- R7: Operand bus values outside the N-cycle stream window, whether before `start` or after the window, have no effect on the result.
- R8: A `start` raised while a product is still in progress is ignored. The result and the `done` timing are those of the block already running.
- R9: `rd_data` shows entry C(`rd_row`, `rd_col`) combinationally. A new `start` may be accepted in the first cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Marks the first stream cycle of a new product (k=0) |
| a_col_in | input | N*AW | Column k of A, one lane per row |
| b_row_in | input | N*BW | Row k of B, one lane per column |
| done | output | 1 | All N×N results are complete |
| rd_row | input | IW | Row index of the entry to read |
| rd_col | input | IW | Column index of the entry to read |
| rd_data | output | CW | Selected result entry |

## Verification
The assertions check the timing contract on every cycle. They confirm that `done` stays low while a product is running and rises on the exact latency cycle. They also check that it holds until the next start, that a read entry stays still while `done` is high, and that the array reads clean before the first start. Only the bench scenarios can show that the arithmetic is right. They cover lane ordering, all-maximum operands, clearing between blocks, junk outside the stream window, a stray start mid-block and back-to-back blocks, each compared against a product computed in the bench.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic {MM_IDLE = 1'b0, MM_RUN = 1'b1} mm_state_e;
endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic clr,
  output logic feed,
  output logic done
);
  import mm_pkg::*;

  localparam int CNTW = $clog2(3 * N);
  localparam logic [CNTW-1:0] LAST_C = CNTW'(3 * N - 3);
  localparam logic [CNTW-1:0] WIN_C  = CNTW'(N);

  mm_state_e       state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            done_q, done_d;
  logic            accept;

  assign accept = start && (state_q == MM_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    if (accept) begin
      state_d = MM_RUN;
      cnt_d   = CNTW'(1);
      done_d  = 1'b0;
    end else if (state_q == MM_RUN) begin
      cnt_d = cnt_q + CNTW'(1);
      if (cnt_q == LAST_C) begin
        state_d = MM_IDLE;
        done_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MM_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign clr  = accept;
  assign feed = accept || ((state_q == MM_RUN) && (cnt_q < WIN_C));
  assign done = done_q;
endmodule

// File: rtl/mm_skew.sv
module mm_skew #(
  parameter int W     = 8,
  parameter int DEPTH = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign dout = din;
    end else begin : g_line
      logic [W-1:0] stage_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int d = 0; d < DEPTH; d++) stage_q[d] <= '0;
        end else begin
          stage_q[0] <= din;
          for (int d = 1; d < DEPTH; d++) stage_q[d] <= stage_q[d-1];
        end
      end
      assign dout = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/mm_pe.sv
module mm_pe #(
  parameter int AW = 8,
  parameter int BW = 8,
  parameter int CW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [AW-1:0] a_in,
  input  logic [BW-1:0] b_in,
  output logic [AW-1:0] a_out,
  output logic [BW-1:0] b_out,
  output logic [CW-1:0] acc
);
  logic [AW+BW-1:0] prod;
  logic [CW-1:0]    acc_q, acc_d;
  logic [AW-1:0]    a_q;
  logic [BW-1:0]    b_q;

  always_comb begin
    prod  = a_in * b_in;
    acc_d = (clr ? '0 : acc_q) + CW'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else begin
      acc_q <= acc_d;
      a_q   <= a_in;
      b_q   <= b_in;
    end
  end

  assign a_out = a_q;
  assign b_out = b_q;
  assign acc   = acc_q;
endmodule

// File: rtl/systolic_mm_top.sv
module systolic_mm_top #(
  parameter int N  = 8,
  parameter int AW = 8,
  parameter int BW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = AW + BW + $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [N*AW-1:0] a_col_in,
  input  logic [N*BW-1:0] b_row_in,
  output logic            done,
  input  logic [IW-1:0]   rd_row,
  input  logic [IW-1:0]   rd_col,
  output logic [CW-1:0]   rd_data
);
  logic clr, feed;

  logic [AW-1:0] a_h [N][N+1];
  logic [BW-1:0] b_v [N+1][N];
  logic [CW-1:0] acc_arr [N][N];

  mm_ctrl #(.N(N)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .clr  (clr),
    .feed (feed),
    .done (done)
  );

  genvar gi, gj;
  generate
    for (gi = 0; gi < N; gi++) begin : g_edge
      logic [AW-1:0] a_gate;
      logic [BW-1:0] b_gate;
      assign a_gate = feed ? a_col_in[gi*AW +: AW] : '0;
      assign b_gate = feed ? b_row_in[gi*BW +: BW] : '0;

      mm_skew #(.W(AW), .DEPTH(gi)) u_askew (
        .clk(clk), .rst_n(rst_n), .din(a_gate), .dout(a_h[gi][0])
      );
      mm_skew #(.W(BW), .DEPTH(gi)) u_bskew (
        .clk(clk), .rst_n(rst_n), .din(b_gate), .dout(b_v[0][gi])
      );
    end

    for (gi = 0; gi < N; gi++) begin : g_row
      for (gj = 0; gj < N; gj++) begin : g_col
        mm_pe #(.AW(AW), .BW(BW), .CW(CW)) u_pe (
          .clk  (clk),
          .rst_n(rst_n),
          .clr  (clr),
          .a_in (a_h[gi][gj]),
          .b_in (b_v[gi][gj]),
          .a_out(a_h[gi][gj+1]),
          .b_out(b_v[gi+1][gj]),
          .acc  (acc_arr[gi][gj])
        );
      end
    end
  endgenerate

  assign rd_data = acc_arr[rd_row][rd_col];
endmodule

// File: rtl/mm_checker.sv
module mm_checker #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int CW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic [IW-1:0] rd_row,
  input logic [IW-1:0] rd_col,
  input logic [CW-1:0] rd_data
);
  localparam int CNTW = $clog2(3 * N);
  localparam logic [CNTW-1:0] LAST_C = CNTW'(3 * N - 3);

  logic            c_busy, seen;
  logic [CNTW-1:0] c_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_busy <= 1'b0;
      c_cnt  <= '0;
      seen   <= 1'b0;
    end else if (start && !c_busy) begin
      c_busy <= 1'b1;
      c_cnt  <= CNTW'(1);
      seen   <= 1'b1;
    end else if (c_busy) begin
      c_cnt <= c_cnt + CNTW'(1);
      if (c_cnt == LAST_C) c_busy <= 1'b0;
    end
  end

  a_r5_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
    c_busy |-> !done);

  a_r5_done_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    (c_busy && c_cnt == LAST_C) |=> done);

  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r6_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (rd_row != $past(rd_row) || rd_col != $past(rd_col)
                          || rd_data == $past(rd_data)));

  a_r3_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (rd_data == '0 && !done));
endmodule

bind systolic_mm_top mm_checker #(.N(N), .IW(IW), .CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .done   (done),
  .rd_row (rd_row),
  .rd_col (rd_col),
  .rd_data(rd_data)
);

// File: tb/sim_systolic_mm_top.sv
module sim_systolic_mm_top;
  localparam int N   = 8;
  localparam int AW  = 8;
  localparam int BW  = 8;
  localparam int IW  = 3;
  localparam int CW  = 19;
  localparam int LAT = 3 * N - 2;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [N*AW-1:0] a_col_in;
  logic [N*BW-1:0] b_row_in;
  logic            done;
  logic [IW-1:0]   rd_row, rd_col;
  logic [CW-1:0]   rd_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [7:0] ma [N][N];
  logic [7:0] mb [N][N];

  always #10 clk = ~clk;

  systolic_mm_top #(.N(N), .AW(AW), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .a_col_in(a_col_in),
    .b_row_in(b_row_in), .done(done), .rd_row(rd_row), .rd_col(rd_col),
    .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic fill(input int mode);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        case (mode)
          0: begin ma[i][j] = (i == j) ? 8'd1 : 8'd0; mb[i][j] = 8'(i * 16 + j); end
          1: begin ma[i][j] = 8'((i * 29 + j * 13 + 3) % 256);
                   mb[i][j] = 8'((i * 7 + j * 41 + 100) % 256); end
          2: begin ma[i][j] = 8'd255; mb[i][j] = 8'd255; end
          default: begin ma[i][j] = 8'(i + j); mb[i][j] = (i == j) ? 8'd2 : 8'd1; end
        endcase
      end
  endtask

  task automatic drive_k(input int k, input bit junk);
    for (int l = 0; l < N; l++) begin
      if (k < N) begin
        a_col_in[l*AW +: AW] = ma[l][k];
        b_row_in[l*BW +: BW] = mb[k][l];
      end else begin
        a_col_in[l*AW +: AW] = junk ? 8'hFF : 8'h00;
        b_row_in[l*BW +: BW] = junk ? 8'(8'hA5 + l) : 8'h00;
      end
    end
  endtask

  // Called at a negedge; returns at the negedge where done must first be high.
  task automatic run_block(input bit junk, input int stray_start_at);
    bit early = 1'b0;
    if (junk) begin
      start = 1'b0;
      drive_k(N, 1'b1);
      repeat (2) @(negedge clk);
    end
    start = 1'b1;
    drive_k(0, junk);
    for (int m = 1; m <= LAT; m++) begin
      @(negedge clk);
      if (m < LAT && done) early = 1'b1;
      start = (m == stray_start_at);
      drive_k(m, junk);
    end
    start = 1'b0;
    chk(!early, "R5", "done high before latency", 1, 0);
    chk(done == 1'b1, "R5", "done at 3N-2 cycles", done, 1);
  endtask

  task automatic check_results(input string req);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int unsigned e = 0;
        for (int k = 0; k < N; k++) e += int'(ma[i][k]) * int'(mb[k][j]);
        rd_row = IW'(i);
        rd_col = IW'(j);
        #1;
        chk(rd_data == CW'(e), req, $sformatf("C(%0d,%0d)", i, j), rd_data, e);
      end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(done == 1'b0, "R3", "done after reset", done, 0);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        rd_row = IW'(i); rd_col = IW'(j); #1;
        chk(rd_data == '0, "R3", "entry after reset", rd_data, 0);
      end
    @(negedge clk);
  endtask

  task automatic t_identity();   // R9 readout, R1 arithmetic
    fill(0); run_block(1'b0, -1); check_results("R9");
  endtask

  task automatic t_pattern();    // R2 lane and k ordering
    fill(1); run_block(1'b0, -1); check_results("R2");
  endtask

  task automatic t_allmax();     // R1 no overflow at 520200
    fill(2); run_block(1'b0, -1); check_results("R1");
  endtask

  task automatic t_clear();      // R4 small product after all-max product
    fill(3); run_block(1'b0, -1); check_results("R4");
  endtask

  task automatic t_junk();       // R7 junk before start and after window
    fill(1); run_block(1'b1, -1); check_results("R7");
  endtask

  task automatic t_stray_start(); // R8 start raised mid-block
    fill(3); run_block(1'b0, 5); check_results("R8");
  endtask

  task automatic t_hold();       // R6 done and results hold under junk buses
    fill(1); run_block(1'b0, -1);
    drive_k(N, 1'b1);
    repeat (12) @(negedge clk);
    chk(done == 1'b1, "R6", "done held", done, 1);
    check_results("R6");
  endtask

  task automatic t_back2back();  // R9 new start in first done cycle
    fill(2); run_block(1'b0, -1);
    fill(1); run_block(1'b0, -1);
    check_results("R9");
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; a_col_in = '0; b_row_in = '0;
    rd_row = '0; rd_col = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_pattern();
    t_allmax();
    t_clear();
    t_junk();
    t_stray_start();
    t_hold();
    t_back2back();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R5 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule